// File: doc/BRIEF.md
# Banked Byte-Addressed Register File

This block is a register file of eight banks. Each bank holds 64 bytes, which can be seen as eight 64-bit rows. Two 64-bit write ports (A and B) and one 64-bit read port each take their own 19-bit control word. The control word picks a bank, one or two byte addresses inside that bank, a direction bit and an access size of 1, 4 or 8 bytes. An access may begin at any byte. A multi-byte access that runs past byte 63 continues at byte 0 of the same bank, so it never leaves the selected bank.

A split read returns two independent 32-bit words from the same bank in one 64-bit result. The read result is registered. It appears on the cycle after the read control word and then stays there until the next read. An active-high disable input blocks every read and every write in the cycle where it is high. Reset clears only the read output. The stored contents have no reset.

Top module: `bankedRegFile`

## Requirements
- R1: The control word bits are bank[18:16], first byte address[15:10], second byte address[9:4], direction[3] (1 = read, 0 = write), split[2] and size[1:0]. Size 2'b11 moves 8 bytes, 2'b10 moves 4 bytes, 2'b01 moves 1 byte, and 2'b00 makes no access.
- R2: A write stores data byte k (bits 8k+7..8k) at byte (first address + k) mod 64 of the selected bank, for k below the access size. All other bytes keep their value.
- R3: A read returns byte (first address + k) mod 64 of the selected bank in output byte k, for k below the access size. The output bytes above the access size read as zero.
- R4: A read with split=1 and size 2'b10 returns the 4 bytes at the first address in bits 31:0 and the 4 bytes at the second address in bits 63:32. Both runs wrap inside the bank. The split bit has no effect on any other read or on writes.
- R5: Both write ports may write in the same cycle. Where they write the same byte, port B's data is stored.
- R6: Read data appears on the output one cycle after its control word. A read sees the contents from before any write in the same cycle. Written data can be read from the next cycle on.
- R7: When no read is made (direction 0 on the read word, or size 2'b00), the read output keeps its previous value.
- R8: While the disable input is 1, no byte is written and the read output keeps its value.
- R9: While the active-low reset is asserted, the read output is zero.
- R10: A write-port control word with direction 1 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the read output |
| holdAll | input | 1 | When 1, blocks all reads and writes this cycle |
| wrDataA | input | 64 | Write data for port A |
| ctlA | input | 19 | Control word for port A |
| wrDataB | input | 64 | Write data for port B |
| ctlB | input | 19 | Control word for port B |
| ctlR | input | 19 | Control word for the read port |
| rdData | output | 64 | Registered read result |

## Verification
The assertions check four behaviours on every cycle. The read output holds when no read is made or when the disable input is high. The output is zero when reset is released. The unused upper bytes of 1-byte reads and unsplit 4-byte reads are zero. Byte placement, wrap-around, the split packing, the port-B priority and the read-before-write order depend on the stored contents, so only the bench's behavioural memory model can show them, by comparing the output every cycle across directed scenarios.

// File: rtl/rfPkg.sv
package rfPkg;
  localparam int NUM_BANKS  = 8;
  localparam int BANK_BYTES = 64;
  localparam int LANES      = 8;
  localparam int DATA_W     = LANES * 8;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int ADDR_W     = $clog2(BANK_BYTES);
  localparam int TOTAL      = NUM_BANKS * BANK_BYTES;
  localparam int HALF       = LANES / 2;
  localparam int CTL_W      = BANK_W + 2 * ADDR_W + 4;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr1;
    logic [ADDR_W-1:0] addr2;
    logic              isRead;
    logic              split;
    logic [1:0]        size;
  } ctlWordT;

  typedef struct packed {
    logic              wrEnA;
    logic              wrEnB;
    logic              rdEn;
    logic              rdSplit;
    logic [ADDR_W-1:0] lenA;
    logic [ADDR_W-1:0] lenB;
    logic [ADDR_W-1:0] lenR;
    logic [BANK_W-1:0] bankA;
    logic [BANK_W-1:0] bankB;
    logic [BANK_W-1:0] bankR;
    logic [ADDR_W-1:0] baseA;
    logic [ADDR_W-1:0] baseB;
    logic [ADDR_W-1:0] baseR;
    logic [ADDR_W-1:0] baseR2;
  } strobeT;

  function automatic logic [ADDR_W-1:0] sizeToLen(input logic [1:0] size);
    case (size)
      2'b11:   return ADDR_W'(LANES);
      2'b10:   return ADDR_W'(HALF);
      2'b01:   return ADDR_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rfControl.sv
module rfControl
  import rfPkg::*;
(
  input  logic    holdAll,
  input  ctlWordT wordA,
  input  ctlWordT wordB,
  input  ctlWordT wordR,
  output strobeT  strobes
);
  logic lenNzA, lenNzB, lenNzR;

  assign lenNzA = (wordA.size != 2'b00);
  assign lenNzB = (wordB.size != 2'b00);
  assign lenNzR = (wordR.size != 2'b00);

  always_comb begin
    strobes         = '0;
    strobes.wrEnA   = !holdAll && !wordA.isRead && lenNzA;
    strobes.wrEnB   = !holdAll && !wordB.isRead && lenNzB;
    strobes.rdEn    = !holdAll && wordR.isRead && lenNzR;
    strobes.rdSplit = wordR.split && (wordR.size == 2'b10);
    strobes.lenA    = sizeToLen(wordA.size);
    strobes.lenB    = sizeToLen(wordB.size);
    strobes.lenR    = sizeToLen(wordR.size);
    strobes.bankA   = wordA.bank;
    strobes.bankB   = wordB.bank;
    strobes.bankR   = wordR.bank;
    strobes.baseA   = wordA.addr1;
    strobes.baseB   = wordB.addr1;
    strobes.baseR   = wordR.addr1;
    strobes.baseR2  = wordR.addr2;
  end
endmodule

// File: rtl/rfDatapath.sv
module rfDatapath
  import rfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrDataA,
  input  logic [DATA_W-1:0] wrDataB,
  input  strobeT            strobes,
  output logic [DATA_W-1:0] rdData
);
  localparam int LANE_W = $clog2(LANES);

  logic [7:0]              mem [TOTAL];
  logic [TOTAL-1:0]        hitA;
  logic [TOTAL-1:0]        hitB;
  logic [TOTAL-1:0][7:0]   byteA;
  logic [TOTAL-1:0][7:0]   byteB;
  logic [DATA_W-1:0]       rdNext;

  // Each byte cell works out which lane of each write port lands on it.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    for (genvar j = 0; j < BANK_BYTES; j++) begin : gByte
      localparam int IDX = b * BANK_BYTES + j;
      localparam logic [ADDR_W-1:0] POS = ADDR_W'(j);
      localparam logic [BANK_W-1:0] BNK = BANK_W'(b);
      logic [ADDR_W-1:0] laneA;
      logic [ADDR_W-1:0] laneB;
      assign laneA = POS - strobes.baseA;
      assign laneB = POS - strobes.baseB;
      assign hitA[IDX] = strobes.wrEnA && (strobes.bankA == BNK) && (laneA < strobes.lenA);
      assign hitB[IDX] = strobes.wrEnB && (strobes.bankB == BNK) && (laneB < strobes.lenB);
      assign byteA[IDX] = wrDataA[8*laneA[LANE_W-1:0] +: 8];
      assign byteB[IDX] = wrDataB[8*laneB[LANE_W-1:0] +: 8];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TOTAL; i++) begin
      if (hitB[i])      mem[i] <= byteB[i];
      else if (hitA[i]) mem[i] <= byteA[i];
    end
  end

  function automatic logic [ADDR_W-1:0] readAddr(input int k);
    if (strobes.rdSplit && k >= HALF)
      return strobes.baseR2 + ADDR_W'(k - HALF);
    return strobes.baseR + ADDR_W'(k);
  endfunction

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < LANES; k++) begin
      if (strobes.rdSplit || k < int'(strobes.lenR))
        rdNext[8*k +: 8] = mem[{strobes.bankR, readAddr(k)}];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobes.rdEn)  rdData <= rdNext;
  end
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import rfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdAll,
  input  logic [DATA_W-1:0] wrDataA,
  input  logic [CTL_W-1:0]  ctlA,
  input  logic [DATA_W-1:0] wrDataB,
  input  logic [CTL_W-1:0]  ctlB,
  input  logic [CTL_W-1:0]  ctlR,
  output logic [DATA_W-1:0] rdData
);
  strobeT strobes;

  rfControl u_control (
    .holdAll (holdAll),
    .wordA   (ctlWordT'(ctlA)),
    .wordB   (ctlWordT'(ctlB)),
    .wordR   (ctlWordT'(ctlR)),
    .strobes (strobes)
  );

  rfDatapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .wrDataA (wrDataA),
    .wrDataB (wrDataB),
    .strobes (strobes),
    .rdData  (rdData)
  );
endmodule

// File: rtl/rfChecker.sv
module rfChecker
  import rfPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              holdAll,
  input logic [CTL_W-1:0]  ctlR,
  input logic [DATA_W-1:0] rdData
);
  logic readReq;
  assign readReq = ctlR[3] && (ctlR[1:0] != 2'b00);

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |=> $stable(rdData)); // R7

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    holdAll |=> $stable(rdData)); // R8

  AST_ZERO_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rdData == '0); // R9

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !holdAll && ctlR[1:0] == 2'b01) |=> rdData[DATA_W-1:8] == '0); // R3

  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !holdAll && ctlR[1:0] == 2'b10 && !ctlR[2])
      |=> rdData[DATA_W-1:DATA_W/2] == '0); // R3
endmodule

bind bankedRegFile rfChecker u_rfChecker (
  .clk     (clk),
  .rstN    (rstN),
  .holdAll (holdAll),
  .ctlR    (ctlR),
  .rdData  (rdData)
);

// File: tb/bankedRegFile_bench.sv
module bankedRegFile_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        holdAll = 1'b0;
  logic [63:0] wrDataA = '0, wrDataB = '0;
  logic [18:0] ctlA = '0, ctlB = '0, ctlR = '0;
  logic [63:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  refMem [8][64];
  logic [63:0] expRd = '0;

  always #(PERIOD/2) clk = ~clk;

  bankedRegFile u_bankedRegFile (
    .clk(clk), .rstN(rstN), .holdAll(holdAll),
    .wrDataA(wrDataA), .ctlA(ctlA), .wrDataB(wrDataB), .ctlB(ctlB),
    .ctlR(ctlR), .rdData(rdData)
  );

  function automatic logic [18:0] mk(int bank, int a1, int a2, bit rd, bit md, int sz);
    return {3'(bank), 6'(a1), 6'(a2), rd, md, 2'(sz)};
  endfunction

  function automatic int lenOf(logic [1:0] sz);
    return (sz == 2'b11) ? 8 : (sz == 2'b10) ? 4 : (sz == 2'b01) ? 1 : 0;
  endfunction

  function automatic logic [63:0] modelRead(logic [18:0] w);
    logic [63:0] r = '0;
    int b = int'(w[18:16]);
    int a1 = int'(w[15:10]);
    int a2 = int'(w[9:4]);
    int n = lenOf(w[1:0]);
    bit sp = w[2] && (w[1:0] == 2'b10);
    for (int k = 0; k < 8; k++) begin
      if (sp) r[8*k +: 8] = (k < 4) ? refMem[b][(a1 + k) % 64] : refMem[b][(a2 + k - 4) % 64];
      else if (k < n) r[8*k +: 8] = refMem[b][(a1 + k) % 64];
    end
    return r;
  endfunction

  function automatic void modelWrite(logic [18:0] w, logic [63:0] d);
    int b = int'(w[18:16]);
    int a1 = int'(w[15:10]);
    if (w[3]) return;
    for (int k = 0; k < lenOf(w[1:0]); k++) refMem[b][(a1 + k) % 64] = d[8*k +: 8];
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s rdData=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: inputs are already driven; update the model at the edge, compare after.
  task automatic step(string tag);
    @(posedge clk);
    if (!rstN) expRd = '0;
    else if (!holdAll) begin
      if (ctlR[3] && ctlR[1:0] != 2'b00) expRd = modelRead(ctlR);
      modelWrite(ctlA, wrDataA);
      modelWrite(ctlB, wrDataB);
    end
    @(negedge clk);
    chk(tag, rdData, expRd);
  endtask

  task automatic drive(logic [18:0] a, logic [63:0] da, logic [18:0] b,
                       logic [63:0] db, logic [18:0] r, bit dis);
    ctlA = a; wrDataA = da; ctlB = b; wrDataB = db; ctlR = r; holdAll = dis;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R9: reset state
    step("R9");
    step("R9");
    chk("R9", rdData, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2: fill all banks with 64-bit writes on both ports
    for (int i = 0; i < 32; i++) begin
      drive(mk(i / 4, (i % 4) * 16, 0, 0, 0, 3),
            64'hF0E1D2C3B4A59687 ^ (64'(i) * 64'h0001000300070011),
            mk(i / 4, (i % 4) * 16 + 8, 0, 0, 0, 3),
            64'h1122334455667788 + (64'(i) * 64'h0101010101010101), 0, 0);
      step("R1_fill");
    end

    // R1 R6: write then read back one cycle later
    drive(mk(0, 0, 0, 0, 0, 3), 64'h00000000DEADBEEF, 0, 0, 0, 0);
    step("R1");
    drive(0, 0, 0, 0, mk(0, 0, 0, 1, 0, 3), 0);
    step("R6");
    chk("R6", rdData, 64'h00000000DEADBEEF);

    // R6: read and write of the same bytes in one cycle returns old data
    drive(mk(0, 0, 0, 0, 0, 3), 64'h0123456789ABCDEF, 0, 0, mk(0, 0, 0, 1, 0, 3), 0);
    step("R6");
    chk("R6", rdData, 64'h00000000DEADBEEF);
    drive(0, 0, 0, 0, mk(0, 0, 0, 1, 0, 3), 0);
    step("R6");
    chk("R6", rdData, 64'h0123456789ABCDEF);

    // R2 R3: write and read wrapping past byte 63
    drive(mk(2, 60, 0, 0, 0, 3), 64'h8877665544332211, 0, 0, 0, 0);
    step("R2");
    drive(0, 0, 0, 0, mk(2, 60, 0, 1, 0, 3), 0);
    step("R3");
    chk("R3", rdData, 64'h8877665544332211);
    drive(0, 0, 0, 0, mk(2, 63, 0, 1, 0, 3), 0);
    step("R3");
    drive(0, 0, 0, 0, mk(2, 0, 0, 1, 0, 3), 0);
    step("R2");
    chk("R2", rdData[31:0], 32'h88776655);

    // R1 R3: byte and 4-byte accesses
    drive(mk(5, 17, 0, 0, 0, 1), 64'hFFFFFFFFFFFFFF5A, mk(5, 62, 0, 0, 0, 2), 64'hFFFFFFFFCAFEF00D, 0, 0);
    step("R1");
    drive(0, 0, 0, 0, mk(5, 17, 0, 1, 0, 1), 0);
    step("R3");
    chk("R3", rdData, 64'h5A);
    drive(0, 0, 0, 0, mk(5, 62, 0, 1, 0, 2), 0);
    step("R3");
    chk("R3", rdData, 64'hCAFEF00D);

    // R4: split read, and split bit ignored elsewhere
    drive(mk(5, 40, 0, 0, 1, 3), 64'hA1A2A3A4B1B2B3B4, 0, 0, mk(5, 62, 8, 1, 1, 2), 0);
    step("R4");
    drive(0, 0, 0, 0, mk(5, 61, 40, 1, 1, 2), 0);
    step("R4");
    drive(0, 0, 0, 0, mk(5, 40, 3, 1, 1, 3), 0);
    step("R4");
    chk("R4", rdData, 64'hA1A2A3A4B1B2B3B4);
    drive(0, 0, 0, 0, mk(5, 40, 3, 1, 1, 1), 0);
    step("R4");
    chk("R4", rdData, 64'hB4);

    // R5: overlapping writes, port B wins
    drive(mk(7, 10, 0, 0, 0, 3), 64'hAAAAAAAAAAAAAAAA, mk(7, 12, 0, 0, 0, 2), 64'h00000000BBBBBBBB, 0, 0);
    step("R5");
    drive(0, 0, 0, 0, mk(7, 10, 0, 1, 0, 3), 0);
    step("R5");
    chk("R5", rdData, 64'hAAAABBBBBBBBAAAA);

    // R7: no read keeps output (direction 0, and size 00)
    drive(0, 0, 0, 0, mk(7, 0, 0, 0, 0, 3), 0);
    step("R7");
    drive(0, 0, 0, 0, mk(7, 0, 0, 1, 0, 0), 0);
    step("R7");
    chk("R7", rdData, 64'hAAAABBBBBBBBAAAA);

    // R10: write ports with direction 1 write nothing
    drive(mk(7, 10, 0, 1, 0, 3), 64'h0, mk(7, 10, 0, 1, 0, 3), 64'h0, 0, 0);
    step("R10");
    drive(0, 0, 0, 0, mk(7, 10, 0, 1, 0, 3), 0);
    step("R10");
    chk("R10", rdData, 64'hAAAABBBBBBBBAAAA);

    // R8: disable blocks writes and reads
    drive(mk(7, 10, 0, 0, 0, 3), 64'h0, mk(3, 0, 0, 0, 0, 3), 64'h0, mk(3, 0, 0, 1, 0, 3), 1);
    step("R8");
    chk("R8", rdData, 64'hAAAABBBBBBBBAAAA);
    drive(0, 0, 0, 0, mk(7, 10, 0, 1, 0, 3), 0);
    step("R8");
    chk("R8", rdData, 64'hAAAABBBBBBBBAAAA);
    drive(0, 0, 0, 0, mk(3, 0, 0, 1, 0, 3), 0);
    step("R8");

    // sweep: reads across every bank and start byte
    for (int i = 0; i < 64; i++) begin
      drive(mk(i % 8, (i * 7) % 64, 0, 0, 0, 1 + i % 3), 64'(i) * 64'h0F1E2D3C4B5A6978,
            mk((i + 3) % 8, (i * 5) % 64, 0, 0, 0, 3 - i % 3), ~(64'(i) * 64'h1357),
            mk(i % 8, (i * 11) % 64, (i * 13) % 64, 1, i % 2 == 1, 1 + i % 3), 0);
      step("R6_sweep");
    end

    drive(0, 0, 0, 0, 0, 0);
    step("R7");
    summary();
  end
endmodule